// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Low-Power Wake

This block collects interrupt events from a set of peripheral sources (five by default) and tells a small processor core which one to service next. Every source has its own pending latch, an enable bit, a two-bit software priority and a flag saying whether it may wake the system from the deep halt state. The winner is the enabled pending source with the highest software priority. Ties go to the source with the lowest index.

The core acknowledges a request to enter its handler and strobes a return when the handler ends. The controller keeps the running priority level in a small level stack. In concurrent mode no handler is ever interrupted. In nested mode a strictly higher priority source preempts the running handler.

Two wake outputs serve the light (wait) and deep (halt) sleep states. While the deep state is active, and after it ends until the first acknowledge, arbitration only looks at halt-capable sources. After that first acknowledge the normal order applies again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, no source is pending, `cur_lvl` is 0, and `irq_req`, `wake_wait`, `wake_halt` and `stk_ovf` are all 0.
- R2: A pulse on `src_evt[i]` sets pending latch i on that clock edge. `irq_req` is 1 while some source is pending, enabled (`src_en[i]`=1) and eligible, and its level is strictly greater than `cur_lvl`. Disabling the source removes the request.
- R3: `irq_vec` carries the index of the winning source as a binary number, and `irq_lvl` carries its level. Both are valid whenever `irq_req` is 1. The level of source i is `src_lvl[2*i+1:2*i]`, read as an unsigned number, so 2'b11 is level 3.
- R4: The highest software level wins. Among equal levels the lowest index wins, so the fixed order from weakest to strongest is main, source 4, 3, 2, 1, 0.
- R5: A pending latch clears only when `clr_data[i]` arrives on a cycle after `clr_stat[i]` has armed it. `clr_data[i]` without a prior arm has no effect. An event that arrives in the cycle the sequence completes is lost.
- R6: When `ack` arrives while `irq_req` is 1, `cur_lvl` is pushed onto the level stack and `cur_lvl` takes the value of `irq_lvl`. `ret` pops the stack into `cur_lvl`. `ret` on an empty stack leaves `cur_lvl` unchanged. `ack` while `irq_req` is 0 has no effect. If `ret` and `ack` arrive together, `ret` wins.
- R7: With `nest_mode`=0 (concurrent), `irq_req` stays 0 while any handler is active, whatever the levels of the pending sources.
- R8: With `nest_mode`=1 (nested), a pending source preempts only if its level is strictly above `cur_lvl`. An equal level does not preempt.
- R9: `wake_wait` is 1 whenever any enabled source is pending.
- R10: `wake_halt` is 1 only when an enabled pending source has its `src_halt_cap` bit set.
- R11: While `halt_mode` is 1, and afterwards until the first accepted `ack`, only halt-capable sources take part in arbitration. After that `ack`, a stronger source that is not halt-capable wins next.
- R12: A push onto a full level stack sets `stk_ovf`, which stays set until reset. The push itself is dropped, but `cur_lvl` is still raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | NSRC | Per-source event pulse that sets the pending latch |
| src_en | input | NSRC | Per-source enable |
| src_lvl | input | NSRC*LVL_W | Packed per-source software levels |
| src_halt_cap | input | NSRC | Per-source halt-wake capability flag |
| clr_stat | input | NSRC | First step of the clear sequence (status access) |
| clr_data | input | NSRC | Second step of the clear sequence (data access) |
| nest_mode | input | 1 | 0 = concurrent, 1 = nested |
| halt_mode | input | 1 | Core is in the deep halt state |
| ack | input | 1 | Core enters the handler of the current winner |
| ret | input | 1 | Core returns from a handler |
| irq_req | output | 1 | A source is ready for service |
| irq_vec | output | VEC_W | Index of the winning source |
| irq_lvl | output | LVL_W | Level of the winning source |
| cur_lvl | output | LVL_W | Level the core is currently running at |
| wake_wait | output | 1 | Wake from the light sleep state |
| wake_halt | output | 1 | Wake from the deep halt state |
| stk_ovf | output | 1 | Sticky level-stack overflow |

## Verification
The bench keeps the default of five sources with two-bit levels, so the full tie-break order and level 3 can be exercised. It shrinks the level stack to a depth of two. With that depth, three nested acknowledges at levels 1, 2 and 3 overflow the stack, and the dropped push shows up on the following returns. With the default depth of four, overflow could not be reached, because levels only go up to 3.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic {
      MODE_CONC = 1'b0,
      MODE_NEST = 1'b1
   } irq_mode_e;
endpackage

// File: rtl/irqc_src_latch.sv
module irqc_src_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic stat_acc,
   input  logic data_acc,
   output logic pend
);
   logic armed;
   logic clr_done;

   assign clr_done = armed & data_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (clr_done)      pend <= 1'b0;
         else if (evt)      pend <= 1'b1;
         if (clr_done)      armed <= 1'b0;
         else if (stat_acc) armed <= 1'b1;
      end
   end

   // R5: a completed two-step clear always leaves the latch empty
   a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && data_acc) |=> !pend);
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
   parameter int NSRC  = 5,
   parameter int LVL_W = 2,
   parameter int VEC_W = 3
) (
   input  logic [NSRC-1:0]       cand,
   input  logic [NSRC*LVL_W-1:0] lvls,
   input  logic [LVL_W-1:0]      cur_lvl,
   input  logic                  allow,
   output logic                  req,
   output logic [VEC_W-1:0]      vec,
   output logic [LVL_W-1:0]      lvl
);
   always_comb begin
      logic             found;
      logic [LVL_W-1:0] best;
      logic [LVL_W-1:0] l;
      found = 1'b0;
      best  = '0;
      vec   = '0;
      // walk from highest index down; >= lets the lower index win ties
      for (int i = NSRC - 1; i >= 0; i--) begin
         l = lvls[i*LVL_W +: LVL_W];
         if (cand[i] && l > cur_lvl && (!found || l >= best)) begin
            found = 1'b1;
            best  = l;
            vec   = VEC_W'(i);
         end
      end
      req = found & allow;
      lvl = best;
   end
endmodule

// File: rtl/irqc_lvl_stack.sv
module irqc_lvl_stack #(
   parameter int LVL_W = 2,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [LVL_W-1:0] push_lvl,
   output logic [LVL_W-1:0] top_lvl,
   output logic             empty,
   output logic             ovf
);
   localparam int PW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [LVL_W-1:0] mem [DEPTH];
   logic [PW-1:0]    ptr;
   logic             full;
   logic [IW-1:0]    wr_idx;
   logic [IW-1:0]    rd_idx;

   assign empty   = (ptr == '0);
   assign full    = (ptr == PW'(DEPTH));
   assign wr_idx  = IW'(ptr);
   assign rd_idx  = IW'(ptr - 1'b1);
   assign top_lvl = empty ? '0 : mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         ovf <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (pop && !empty) begin
         ptr <= ptr - 1'b1;
      end else if (push) begin
         if (full) ovf <= 1'b1;
         else begin
            mem[wr_idx] <= push_lvl;
            ptr         <= ptr + 1'b1;
         end
      end
   end

   // R12: pushing a full stack sets the sticky flag
   a_r12_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && full) |=> ovf);
   // R12: the flag never drops once raised
   a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int NSRC      = 5,
   parameter int LVL_W     = 2,
   parameter int STK_DEPTH = 4,
   localparam int VEC_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSRC-1:0]       src_evt,
   input  logic [NSRC-1:0]       src_en,
   input  logic [NSRC*LVL_W-1:0] src_lvl,
   input  logic [NSRC-1:0]       src_halt_cap,
   input  logic [NSRC-1:0]       clr_stat,
   input  logic [NSRC-1:0]       clr_data,
   input  logic                  nest_mode,
   input  logic                  halt_mode,
   input  logic                  ack,
   input  logic                  ret,
   output logic                  irq_req,
   output logic [VEC_W-1:0]      irq_vec,
   output logic [LVL_W-1:0]      irq_lvl,
   output logic [LVL_W-1:0]      cur_lvl,
   output logic                  wake_wait,
   output logic                  wake_halt,
   output logic                  stk_ovf
);
   import irqc_pkg::*;

   if (NSRC < 2 || NSRC > 16) begin : g_bad_nsrc
      $error("irq_prio_ctrl: NSRC must lie in 2..16");
   end
   if (LVL_W < 1 || LVL_W > 4) begin : g_bad_lvl
      $error("irq_prio_ctrl: LVL_W must lie in 1..4");
   end
   if (STK_DEPTH < 1 || STK_DEPTH > 64) begin : g_bad_depth
      $error("irq_prio_ctrl: STK_DEPTH must lie in 1..64");
   end

   logic [NSRC-1:0]  pend;
   logic [NSRC-1:0]  live;
   logic [NSRC-1:0]  cand;
   logic             halt_first;
   logic             restrict_q;
   logic             stk_empty;
   logic [LVL_W-1:0] stk_top;
   logic             ack_ok;
   logic             do_pop;
   logic             allow;
   irq_mode_e        mode;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      irqc_src_latch u_latch (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (src_evt[i]),
         .stat_acc (clr_stat[i]),
         .data_acc (clr_data[i]),
         .pend     (pend[i])
      );
   end

   assign mode       = irq_mode_e'(nest_mode);
   assign live       = pend & src_en;
   assign restrict_q = halt_mode | halt_first;
   assign cand       = restrict_q ? (live & src_halt_cap) : live;
   assign allow      = (mode == MODE_NEST) || stk_empty;
   assign wake_wait  = |live;
   assign wake_halt  = |(live & src_halt_cap);
   assign do_pop     = ret && !stk_empty;
   assign ack_ok     = ack && irq_req && !ret;

   irqc_arb #(.NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_arb (
      .cand    (cand),
      .lvls    (src_lvl),
      .cur_lvl (cur_lvl),
      .allow   (allow),
      .req     (irq_req),
      .vec     (irq_vec),
      .lvl     (irq_lvl)
   );

   irqc_lvl_stack #(.LVL_W(LVL_W), .DEPTH(STK_DEPTH)) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ack_ok),
      .pop      (ret),
      .push_lvl (cur_lvl),
      .top_lvl  (stk_top),
      .empty    (stk_empty),
      .ovf      (stk_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_lvl    <= '0;
         halt_first <= 1'b0;
      end else begin
         if (do_pop)      cur_lvl <= stk_top;
         else if (ack_ok) cur_lvl <= irq_lvl;
         if (halt_mode)   halt_first <= 1'b1;
         else if (ack_ok) halt_first <= 1'b0;
      end
   end

   // R7: concurrent mode never offers a request while a handler runs
   a_r7_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
      (!nest_mode && !stk_empty) |-> !irq_req);
   // R6: an accepted acknowledge raises the running level to the winner's
   a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_req && !ret) |=> (cur_lvl == $past(irq_lvl)));
   // R10: halt wake implies wait wake
   a_r10_halt_subset: assert property (@(posedge clk) disable iff (!rst_n)
      wake_halt |-> wake_wait);
   // R11: the winner is halt-capable during and right after halt
   a_r11_capable_first: assert property (@(posedge clk) disable iff (!rst_n)
      (restrict_q && irq_req) |-> ((src_halt_cap >> irq_vec) & 1) != 0);
   // R2: the request always refers to an enabled pending source above the level
   a_r2_req_valid: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (((live >> irq_vec) & 1) != 0) && (irq_lvl > cur_lvl));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
   localparam int NSRC = 5;
   localparam int LW   = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_evt = '0, src_en = '0, src_halt_cap = '0;
   logic [NSRC-1:0] clr_stat = '0, clr_data = '0;
   logic [NSRC*LW-1:0] src_lvl = '0;
   logic nest_mode = 1'b0, halt_mode = 1'b0, ack = 1'b0, ret = 1'b0;
   logic irq_req, wake_wait, wake_halt, stk_ovf;
   logic [2:0]    irq_vec;
   logic [LW-1:0] irq_lvl, cur_lvl;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   irq_prio_ctrl #(.NSRC(NSRC), .LVL_W(LW), .STK_DEPTH(2)) dut (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_en(src_en),
      .src_lvl(src_lvl), .src_halt_cap(src_halt_cap), .clr_stat(clr_stat),
      .clr_data(clr_data), .nest_mode(nest_mode), .halt_mode(halt_mode),
      .ack(ack), .ret(ret), .irq_req(irq_req), .irq_vec(irq_vec),
      .irq_lvl(irq_lvl), .cur_lvl(cur_lvl), .wake_wait(wake_wait),
      .wake_halt(wake_halt), .stk_ovf(stk_ovf)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_lvl(input int s, input int l);
      src_lvl[s*LW +: LW] = LW'(l);
   endtask

   task automatic pulse_evt(input logic [NSRC-1:0] m);
      @(negedge clk) src_evt = m;
      @(negedge clk) src_evt = '0;
   endtask

   task automatic do_ack();
      @(negedge clk) ack = 1'b1;
      @(negedge clk) ack = 1'b0;
   endtask

   task automatic do_ret();
      @(negedge clk) ret = 1'b1;
      @(negedge clk) ret = 1'b0;
   endtask

   task automatic clear_all();
      @(negedge clk) clr_stat = '1;
      @(negedge clk) begin clr_stat = '0; clr_data = '1; end
      @(negedge clk) clr_data = '0;
   endtask

   task automatic t_reset();
      chk("R1 req", irq_req, 0);
      chk("R1 cur_lvl", cur_lvl, 0);
      chk("R1 wake_wait", wake_wait, 0);
      chk("R1 wake_halt", wake_halt, 0);
      chk("R1 ovf", stk_ovf, 0);
   endtask

   task automatic t_basic();
      src_en = '1;
      for (int i = 0; i < NSRC; i++) set_lvl(i, 1);
      pulse_evt(5'b00100);
      chk("R2 req", irq_req, 1);
      chk("R3 vec", irq_vec, 2);
      chk("R3 lvl", irq_lvl, 1);
      chk("R9 wake_wait", wake_wait, 1);
      chk("R10 wake_halt no cap", wake_halt, 0);
      @(negedge clk) src_en = 5'b11011;
      #1 chk("R2 disabled", irq_req, 0);
      @(negedge clk) src_en = '1;
   endtask

   task automatic t_clear();
      @(negedge clk) clr_data = 5'b00100;
      @(negedge clk) clr_data = '0;
      chk("R5 data alone", irq_req, 1);
      @(negedge clk) clr_stat = 5'b00100;
      @(negedge clk) begin clr_stat = '0; clr_data = 5'b00100; end
      @(negedge clk) clr_data = '0;
      chk("R5 cleared", irq_req, 0);
      @(negedge clk) clr_stat = 5'b01000;
      @(negedge clk) begin clr_stat = '0; clr_data = 5'b01000; src_evt = 5'b01000; end
      @(negedge clk) begin clr_data = '0; src_evt = '0; end
      chk("R5 event lost", wake_wait, 0);
   endtask

   task automatic t_tie();
      pulse_evt(5'b01010);
      chk("R4 tie low index", irq_vec, 1);
      @(negedge clk) set_lvl(4, 2);
      pulse_evt(5'b10000);
      chk("R4 higher sw level", irq_vec, 4);
      chk("R3 lvl 2", irq_lvl, 2);
      clear_all();
      set_lvl(4, 1);
   endtask

   task automatic t_concurrent();
      nest_mode = 1'b0;
      set_lvl(0, 3);
      pulse_evt(5'b01000);
      do_ack();
      chk("R6 raise", cur_lvl, 1);
      pulse_evt(5'b00001);
      chk("R7 no preempt", irq_req, 0);
      do_ret();
      chk("R6 restore", cur_lvl, 0);
      chk("R7 after ret", irq_vec, 0);
      clear_all();
   endtask

   task automatic t_nested();
      nest_mode = 1'b1;
      set_lvl(0, 1); set_lvl(2, 2);
      pulse_evt(5'b01000);
      do_ack();
      pulse_evt(5'b10000);
      chk("R8 equal no preempt", irq_req, 0);
      pulse_evt(5'b00100);
      chk("R8 preempt req", irq_req, 1);
      chk("R8 preempt vec", irq_vec, 2);
      do_ack();
      chk("R6 nested raise", cur_lvl, 2);
      do_ret();
      chk("R6 pop one", cur_lvl, 1);
      do_ret();
      chk("R6 pop two", cur_lvl, 0);
      clear_all();
      do_ack();
      chk("R6 ack no req ignored", cur_lvl, 0);
   endtask

   task automatic t_overflow();
      set_lvl(0, 3); set_lvl(1, 2); set_lvl(2, 1);
      pulse_evt(5'b00100); do_ack();
      pulse_evt(5'b00010); do_ack();
      chk("R12 no ovf yet", stk_ovf, 0);
      pulse_evt(5'b00001); do_ack();
      chk("R12 ovf set", stk_ovf, 1);
      chk("R12 level raised", cur_lvl, 3);
      do_ret();
      chk("R12 dropped push", cur_lvl, 1);
      do_ret();
      chk("R12 bottom", cur_lvl, 0);
      do_ret();
      chk("R6 empty ret", cur_lvl, 0);
      chk("R12 sticky", stk_ovf, 1);
      clear_all();
   endtask

   task automatic t_halt();
      src_halt_cap = 5'b01000;
      set_lvl(0, 3); set_lvl(3, 1);
      @(negedge clk) halt_mode = 1'b1;
      pulse_evt(5'b00001);
      chk("R9 wake_wait", wake_wait, 1);
      chk("R10 not capable", wake_halt, 0);
      chk("R11 no req", irq_req, 0);
      pulse_evt(5'b01000);
      chk("R10 capable", wake_halt, 1);
      chk("R11 capable vec", irq_vec, 3);
      @(negedge clk) halt_mode = 1'b0;
      @(negedge clk);
      chk("R11 after exit", irq_vec, 3);
      do_ack();
      chk("R11 first lvl", cur_lvl, 1);
      chk("R11 next req", irq_req, 1);
      chk("R11 next vec", irq_vec, 0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_clear();
      t_tie();
      t_concurrent();
      t_nested();
      t_overflow();
      t_halt();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule